// File: doc/BRIEF.md
# PIO Receive Frame Reader

This block is a hardware sequencer that drains one received frame from a programmed-I/O receive queue. The queue is reached through a 16-bit register master port with two addresses, a control register and a data register. A one-cycle `start` pulse, together with the number of the queue, launches a read. The sequencer first checks that the queue holds something and acknowledges it. It then polls until data is ready, giving up after a bounded time. Next it reads a length word and a receive header whose size depends on the queue, and checks the frame against the length and flag rules. Finally it streams the payload out as bytes, each tagged with its offset in the frame buffer.

At the end of each read `done` pulses for one cycle. `got_frame` and `err_code` report the outcome and hold their values until the next start. The header words collected during the read stay visible on `hdr_buf`, zero-padded to 30 bytes. The block does not interpret the frame contents beyond the two header flags it needs.

Top module: `pio_rx_reader`

## Requirements
- R1: After reset, `reg_req`, `done` and `out_valid` are low, and `err_code` is 0 and `got_frame` is 0.
- R2: A start first reads the control register (reg_addr 0). If bit 0 of that value is clear, the block makes no further register access and pulses `done` with `got_frame`=0 and `err_code`=0.
- R3: If bit 0 is set, the block writes 1 to control and then reads control until bit 1 is set. Consecutive polls are between INTERVAL and INTERVAL+4 cycles apart, where INTERVAL = CYC_PER_US*POLL_US (20 by default). After POLL_LIMIT (10) polls that all read bit 1 clear, the result is `err_code`=1 (timeout).
- R4: The first data-register read (reg_addr 1) is the length. A length above 0x700 gives `err_code`=2 and a length of 0 gives `err_code`=3, except on queue 4. In both cases the block reads no more data words.
- R5: After the length, the header is read as 16-bit words: 7 words on queue 4 and 9 words on the other queues. `hdr_buf` holds the length in word 0 and header word k in bits [16k+15:16k]. Every word above the ones read, up to 30 bytes in all, is zero.
- R6: Header word 3 carries the frame flags: bit 0 marks an invalid frame and bit 2 a type-2 frame. An invalid frame gives `err_code`=4. On queue 1 the block first makes 15 extra data reads.
- R7: On queue 4 a valid frame ends after the header, with `got_frame`=1 and no payload byte.
- R8: Every error ends with a write of 2 to control, followed by the `done` pulse. No other write of 2 occurs.
- R9: The payload is read in 16-bit words, the low byte output before the high byte, one `out_valid` pulse per byte. For an even length, byte k goes to offset BASE+k, where BASE is 0x20 for a type-2 frame and 0x1E otherwise.
- R10: For an odd length, the paired bytes go to offsets BASE+1 onward. A final read supplies one byte (its low half), which goes to offset BASE. A length of 0x700 is accepted in full.
- R11: A register request holds its address, direction and write data steady until `reg_ack`. A transfer completes in a cycle where both `reg_req` and `reg_ack` are high.
- R12: The queue is selected by `queue_sel`: 0 is queue 1, 1 is queue 2, 2 is queue 3 and 3 is queue 4. The value is sampled at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches a frame read while idle |
| queue_sel | input | 2 | Queue number minus one, sampled at start |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 for a write, 0 for a read |
| reg_addr | output | 1 | 0 selects control, 1 selects data |
| reg_wdata | output | 16 | Write data |
| reg_ack | input | 1 | Access completes while high with `reg_req` |
| reg_rdata | input | 16 | Read data, valid with `reg_ack` |
| out_valid | output | 1 | A payload byte is present |
| out_byte | output | 8 | Payload byte |
| out_offset | output | 12 | Frame-buffer offset of the byte |
| hdr_buf | output | 240 | Length word and header words, zero-padded |
| done | output | 1 | One-cycle pulse at the end of a read |
| got_frame | output | 1 | A frame was delivered without error |
| err_code | output | 3 | 0 none, 1 timeout, 2 too long, 3 zero length, 4 invalid |

## Verification
The reader is driven by a register responder that answers with fixed frames. The patterns are an empty queue, a queue that never becomes ready, and one that is ready only after two polls. Frames are sent with lengths of 0, 1 above the maximum, the maximum itself, and odd and even values. The invalid and type-2 flags are each set and clear, and each queue is used. The empty and never-ready cases tell the early exit apart from the timeout path, and the poll timestamps check the spacing. The length and queue variants tell the per-queue header sizes and the zero-length exemption apart. The flag and parity variants separate the two base offsets, show where the odd byte lands, and show the extra reads that only queue 1 makes.

// File: rtl/pio_rx_pkg.sv
// Package: shared encodings of the receive frame reader.
// Assumes: one control and one data register behind a 16-bit port.
package pio_rx_pkg;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_TIMEOUT  = 3'd1,
        ERR_TOO_LONG = 3'd2,
        ERR_ZERO_LEN = 3'd3,
        ERR_INVALID  = 3'd4
    } rx_err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_AVAIL, S_ACK, S_POLL, S_WAIT, S_LEN, S_HDR,
        S_PAY, S_PHI, S_ODD, S_DUMMY, S_ERRWR, S_DONE
    } rx_state_e;

    localparam logic REG_CTRL = 1'b0;
    localparam logic REG_DATA = 1'b1;

endpackage

// File: rtl/pio_rx_poll_timer.sv
// Module: paces the ready polls and counts them.
// A load starts a wait of INTERVAL cycles that ends with one expire pulse;
// each expire counts a failed poll. restart clears the count.
// Assumes: load never comes while a wait is running.
module pio_rx_poll_timer #(
    parameter int INTERVAL = 20,
    parameter int LIMIT    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic load,
    output logic expire,
    output logic last_try
);
    localparam int CW = $clog2(INTERVAL + 1);
    localparam int TW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;
    logic [TW-1:0] tries;
    logic          running;

    assign expire   = running && (cnt == '0);
    assign last_try = (tries == TW'(LIMIT - 1));

    // Count down the wait and advance the poll count on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            tries   <= '0;
            running <= 1'b0;
        end else begin
            if (restart) tries <= '0;
            if (load) begin
                running <= 1'b1;
                cnt     <= CW'(INTERVAL - 1);
            end else if (running) begin
                if (cnt == '0) begin
                    running <= 1'b0;
                    tries   <= tries + 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R3
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !running);

    // R3
    try_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tries < TW'(LIMIT));

endmodule

// File: rtl/pio_rx_hdr_store.sv
// Module: the header buffer, one 16-bit register per word.
// clr zeroes every word. A write lands in word widx, low byte at the
// lower address. Words that are never written stay zero.
module pio_rx_hdr_store #(
    parameter int WORDS = 15,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  we,
    input  logic [IW-1:0]         widx,
    input  logic [15:0]           wdata,
    output logic [16*WORDS-1:0]   hdr
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [15:0] word_q;
        // Hold one header word: cleared at start, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) word_q <= '0;
            else if (we && (widx == IW'(w))) word_q <= wdata;
        end
        assign hdr[16*w +: 16] = word_q;
    end

endmodule

// File: rtl/pio_rx_reader.sv
// Module: top of the receive frame reader.
// The block checks availability, acknowledges, polls for ready with a
// timeout, reads the length and a header sized by the queue, and checks
// both. It then streams the payload as offset-tagged bytes; any error
// ends with a write of 2 to control.
// Assumes: the responder holds reg_rdata valid while reg_ack is high.
module pio_rx_reader
    import pio_rx_pkg::*;
#(
    parameter int          CYC_PER_US = 2,
    parameter int          POLL_US    = 10,
    parameter int          POLL_LIMIT = 10,
    parameter logic [15:0] MAX_LEN    = 16'h0700,
    parameter int          HDR_BYTES  = 30,
    parameter int          FLG_WORD   = 3,
    parameter int          INV_BIT    = 0,
    parameter int          T2_BIT     = 2,
    parameter int          DUMMY_N    = 15,
    parameter int          OFF_W      = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [1:0]             queue_sel,
    output logic                   reg_req,
    output logic                   reg_we,
    output logic                   reg_addr,
    output logic [15:0]            reg_wdata,
    input  logic                   reg_ack,
    input  logic [15:0]            reg_rdata,
    output logic                   out_valid,
    output logic [7:0]             out_byte,
    output logic [OFF_W-1:0]       out_offset,
    output logic [8*HDR_BYTES-1:0] hdr_buf,
    output logic                   done,
    output logic                   got_frame,
    output logic [2:0]             err_code
);
    localparam int INTERVAL  = CYC_PER_US * POLL_US;
    localparam int HDR_WORDS = HDR_BYTES / 2;
    localparam int IW        = $clog2(HDR_WORDS);
    localparam int STD_WORDS = (2 + 18) / 2;
    localparam int Q4_WORDS  = (2 + 14) / 2;
    localparam int DW        = $clog2(DUMMY_N + 1);
    localparam logic [OFF_W-1:0] BASE_STD = OFF_W'(12'h01E);
    localparam logic [OFF_W-1:0] BASE_T2  = OFF_W'(12'h020);

    rx_state_e        state;
    logic [1:0]       q;
    logic [15:0]      len;
    logic [IW-1:0]    hidx;
    logic [14:0]      wcnt;
    logic [DW-1:0]    dcnt;
    logic [OFF_W-1:0] pay_off;
    logic [OFF_W-1:0] base_off;
    logic [7:0]       hi_byte;

    logic xfer, is_q4, is_q1, flag_inv, flag_t2, expire, last_try;
    logic [IW-1:0]    last_idx;
    logic [OFF_W-1:0] hdr_base;

    assign xfer     = reg_req && reg_ack;
    assign is_q4    = (q == 2'd3);
    assign is_q1    = (q == 2'd0);
    assign last_idx = is_q4 ? IW'(Q4_WORDS - 1) : IW'(STD_WORDS - 1);
    assign flag_inv = hdr_buf[16*FLG_WORD + INV_BIT];
    assign flag_t2  = hdr_buf[16*FLG_WORD + T2_BIT];
    assign hdr_base = flag_t2 ? BASE_T2 : BASE_STD;
    assign done     = (state == S_DONE);

    // Drive the register request that the current state needs.
    always_comb begin
        reg_req   = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = REG_CTRL;
        reg_wdata = 16'd0;
        case (state)
            S_AVAIL, S_POLL: reg_req = 1'b1;
            S_ACK: begin
                reg_req = 1'b1; reg_we = 1'b1; reg_wdata = 16'd1;
            end
            S_ERRWR: begin
                reg_req = 1'b1; reg_we = 1'b1; reg_wdata = 16'd2;
            end
            S_LEN, S_HDR, S_DUMMY, S_PAY, S_ODD: begin
                reg_req = 1'b1; reg_addr = REG_DATA;
            end
            default: ;
        endcase
    end

    pio_rx_poll_timer #(.INTERVAL(INTERVAL), .LIMIT(POLL_LIMIT)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (xfer && (state == S_ACK)),
        .load     (xfer && (state == S_POLL) && !reg_rdata[1] && !last_try),
        .expire   (expire),
        .last_try (last_try)
    );

    pio_rx_hdr_store #(.WORDS(HDR_WORDS)) i_hdr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((state == S_IDLE) && start),
        .we    (xfer && ((state == S_LEN) || (state == S_HDR))),
        .widx  ((state == S_LEN) ? '0 : hidx),
        .wdata (reg_rdata),
        .hdr   (hdr_buf)
    );

    // Sequence the frame read, check it, and emit payload bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            q          <= '0;
            len        <= '0;
            hidx       <= '0;
            wcnt       <= '0;
            dcnt       <= '0;
            pay_off    <= '0;
            base_off   <= '0;
            hi_byte    <= '0;
            err_code   <= ERR_NONE;
            got_frame  <= 1'b0;
            out_valid  <= 1'b0;
            out_byte   <= '0;
            out_offset <= '0;
        end else begin
            out_valid <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    q         <= queue_sel;
                    hidx      <= '0;
                    err_code  <= ERR_NONE;
                    got_frame <= 1'b0;
                    state     <= S_AVAIL;
                end
                S_AVAIL: if (xfer) state <= reg_rdata[0] ? S_ACK : S_DONE;
                S_ACK:   if (xfer) state <= S_POLL;
                S_POLL: if (xfer) begin
                    if (reg_rdata[1]) state <= S_LEN;
                    else if (last_try) begin
                        err_code <= ERR_TIMEOUT;
                        state    <= S_ERRWR;
                    end else state <= S_WAIT;
                end
                S_WAIT: if (expire) state <= S_POLL;
                S_LEN: if (xfer) begin
                    len  <= reg_rdata;
                    hidx <= IW'(1);
                    if (reg_rdata > MAX_LEN) begin
                        err_code <= ERR_TOO_LONG;
                        state    <= S_ERRWR;
                    end else if ((reg_rdata == 16'd0) && !is_q4) begin
                        err_code <= ERR_ZERO_LEN;
                        state    <= S_ERRWR;
                    end else state <= S_HDR;
                end
                S_HDR: if (xfer) begin
                    hidx <= hidx + 1'b1;
                    if (hidx == last_idx) begin
                        if (flag_inv) begin
                            err_code <= ERR_INVALID;
                            dcnt     <= '0;
                            state    <= is_q1 ? S_DUMMY : S_ERRWR;
                        end else if (is_q4) begin
                            got_frame <= 1'b1;
                            state     <= S_DONE;
                        end else begin
                            base_off <= hdr_base;
                            pay_off  <= hdr_base + OFF_W'(len[0]);
                            wcnt     <= '0;
                            state    <= (len[15:1] == 15'd0) ? S_ODD : S_PAY;
                        end
                    end
                end
                S_PAY: if (xfer) begin
                    out_valid  <= 1'b1;
                    out_byte   <= reg_rdata[7:0];
                    out_offset <= pay_off;
                    pay_off    <= pay_off + 1'b1;
                    hi_byte    <= reg_rdata[15:8];
                    state      <= S_PHI;
                end
                S_PHI: begin
                    out_valid  <= 1'b1;
                    out_byte   <= hi_byte;
                    out_offset <= pay_off;
                    pay_off    <= pay_off + 1'b1;
                    wcnt       <= wcnt + 1'b1;
                    if (wcnt == len[15:1] - 15'd1) begin
                        if (len[0]) state <= S_ODD;
                        else begin
                            got_frame <= 1'b1;
                            state     <= S_DONE;
                        end
                    end else state <= S_PAY;
                end
                S_ODD: if (xfer) begin
                    out_valid  <= 1'b1;
                    out_byte   <= reg_rdata[7:0];
                    out_offset <= base_off;
                    got_frame  <= 1'b1;
                    state      <= S_DONE;
                end
                S_DUMMY: if (xfer) begin
                    dcnt <= dcnt + 1'b1;
                    if (dcnt == DW'(DUMMY_N - 1)) state <= S_ERRWR;
                end
                S_ERRWR: if (xfer) state <= S_DONE;
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_ack |=> reg_req && $stable({reg_we, reg_addr, reg_wdata}));

    // R8
    err_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && (err_code != ERR_NONE) |->
            $past(xfer && reg_we && (reg_wdata == 16'd2)));

    // R9
    pay_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_offset >= BASE_STD) && (out_offset < BASE_T2 + OFF_W'(MAX_LEN)));

    // R7
    q4_no_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !is_q4);

    // R5
    hdr_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_buf[16*HDR_WORDS-1:16*STD_WORDS] == '0);

    // R2
    got_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && got_frame |-> err_code == ERR_NONE);

endmodule

// File: tb/test_pio_rx_reader.sv
module test_pio_rx_reader;
    localparam int INTERVAL = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   queue_sel = 2'd0;
    logic         reg_req, reg_we, reg_addr;
    logic [15:0]  reg_wdata;
    logic         reg_ack = 1'b0;
    logic [15:0]  reg_rdata = 16'd0;
    logic         out_valid;
    logic [7:0]   out_byte;
    logic [11:0]  out_offset;
    logic [239:0] hdr_buf;
    logic         done, got_frame;
    logic [2:0]   err_code;

    always #10 clk = ~clk;

    pio_rx_reader i_pio_rx_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .queue_sel(queue_sel),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .out_valid(out_valid), .out_byte(out_byte), .out_offset(out_offset),
        .hdr_buf(hdr_buf), .done(done), .got_frame(got_frame), .err_code(err_code)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // responder state
    logic        avail = 1'b1;
    int          ready_after = 1;
    logic [15:0] fifo [0:1023];
    int          dlen = 0;
    int          n_ctrl_rd, n_ctrl_wr, n_data_rd;
    int          wr_hist [0:7];
    int          rd_cyc  [0:31];
    logic [7:0]  cap     [0:2047];
    logic        cap_set [0:2047];
    int          n_out;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // register responder: ack one cycle after request, log at completion
    always @(posedge clk) begin
        if (!rst_n) reg_ack <= 1'b0;
        else if (reg_req && reg_ack) begin
            reg_ack <= 1'b0;
            if (reg_we) begin
                if (n_ctrl_wr < 8) wr_hist[n_ctrl_wr] = int'(reg_wdata);
                n_ctrl_wr++;
            end else if (!reg_addr) begin
                if (n_ctrl_rd < 32) rd_cyc[n_ctrl_rd] = cyc;
                n_ctrl_rd++;
            end else n_data_rd++;
        end else if (reg_req) begin
            reg_ack <= 1'b1;
            if (!reg_addr)
                reg_rdata <= {14'd0, (n_ctrl_rd >= ready_after), avail};
            else
                reg_rdata <= (n_data_rd < dlen) ? fifo[n_data_rd] : 16'd0;
        end
    end

    always @(posedge clk) begin
        if (out_valid) begin
            cap[out_offset]     = out_byte;
            cap_set[out_offset] = 1'b1;
            n_out++;
        end
    end

    task automatic clear_log();
        n_ctrl_rd = 0; n_ctrl_wr = 0; n_data_rd = 0; n_out = 0;
        for (int i = 0; i < 2048; i++) begin cap[i] = 8'h00; cap_set[i] = 1'b0; end
    endtask

    // build a frame: length word, header words, payload words
    task automatic build(input int len, input logic [15:0] flags, input int nh);
        fifo[0] = 16'(len);
        for (int k = 1; k < nh; k++) fifo[k] = (k == 3) ? flags : 16'(16'hA100 + k);
        for (int i = 0; i < (len + 1) / 2; i++)
            fifo[nh + i] = {8'(8'h41 + 2 * i), 8'(8'h40 + 2 * i)};
        if (len % 2 == 1) fifo[nh + len / 2] = {8'hEE, 8'(8'h40 + len - 1)};
        dlen = nh + (len + 1) / 2;
    endtask

    task automatic run(input logic [1:0] qs, output bit ok);
        clear_log();
        @(negedge clk); start = 1'b1; queue_sel = qs;
        @(negedge clk); start = 1'b0;
        ok = 1'b0;
        for (int t = 0; t < 20000; t++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        check(ok, "watchdog done", 0, 1);
    endtask

    task automatic check_payload(input string tag, input int len, input int base);
        int bad = 0;
        for (int k = 0; k < len; k++) begin
            logic [7:0] e;
            e = (len % 2 == 1) ? ((k == 0) ? 8'(8'h40 + len - 1) : 8'(8'h40 + k - 1))
                               : 8'(8'h40 + k);
            if (!cap_set[base + k] || cap[base + k] != e) bad++;
        end
        check(bad == 0, tag, bad, 0);
        check(n_out == len, {tag, " byte count"}, n_out, len);
    endtask

    task automatic t_reset();
        check(!reg_req && !done && !out_valid, "R1 idle outputs", {reg_req, done, out_valid}, 0);
        check(err_code == 3'd0 && !got_frame, "R1 status", err_code, 0);
    endtask

    task automatic t_empty();
        bit ok;
        avail = 1'b0; ready_after = 1;
        run(2'd1, ok);
        check(!got_frame && err_code == 3'd0, "R2 empty status", {got_frame, err_code}, 0);
        @(negedge clk);
        check(n_ctrl_rd == 1 && n_ctrl_wr == 0 && n_data_rd == 0, "R2 single access",
              n_ctrl_rd + 16 * n_ctrl_wr + 256 * n_data_rd, 1);
        avail = 1'b1;
    endtask

    task automatic t_timeout();
        bit ok;
        int mn = 1000, mx = 0;
        ready_after = 1000;
        run(2'd0, ok);
        check(err_code == 3'd1 && !got_frame, "R3 timeout code", err_code, 1);
        check(n_ctrl_rd - 1 == 10, "R3 poll count", n_ctrl_rd - 1, 10);
        for (int i = 2; i < n_ctrl_rd && i < 32; i++) begin
            if (rd_cyc[i] - rd_cyc[i-1] < mn) mn = rd_cyc[i] - rd_cyc[i-1];
            if (rd_cyc[i] - rd_cyc[i-1] > mx) mx = rd_cyc[i] - rd_cyc[i-1];
        end
        check(mn >= INTERVAL && mx <= INTERVAL + 4, "R3 poll spacing", mn, INTERVAL);
        check(n_ctrl_wr == 2 && wr_hist[0] == 1 && wr_hist[1] == 2, "R8 ack then error write",
              wr_hist[1], 2);
        ready_after = 1;
    endtask

    task automatic t_late_ready();
        bit ok;
        ready_after = 3;
        build(4, 16'h0000, 10);
        run(2'd1, ok);
        check(got_frame && err_code == 3'd0 && n_ctrl_rd == 4, "R3 ready after two polls",
              n_ctrl_rd, 4);
        ready_after = 1;
    endtask

    task automatic t_too_long();
        bit ok;
        build(0, 16'h0000, 10); fifo[0] = 16'h0701; dlen = 10;
        run(2'd1, ok);
        check(err_code == 3'd2 && n_data_rd == 1, "R4 too long", err_code, 2);
        check(n_ctrl_wr == 2 && wr_hist[1] == 2, "R8 too long write", wr_hist[1], 2);
    endtask

    task automatic t_zero();
        bit ok;
        build(0, 16'h0000, 10);
        run(2'd0, ok);
        check(err_code == 3'd3 && n_data_rd == 1, "R4 zero length queue 1", err_code, 3);
        build(0, 16'h0000, 8);
        run(2'd3, ok);
        check(err_code == 3'd0 && got_frame && n_data_rd == 8, "R4 zero length queue 4",
              n_data_rd, 8);
    endtask

    task automatic t_q4_hdr();
        bit ok;
        int bad = 0;
        build(5, 16'h0004, 8);
        run(2'd3, ok);
        check(got_frame && n_out == 0 && n_data_rd == 8, "R7 queue 4 header only", n_out, 0);
        for (int k = 0; k < 8; k++) if (hdr_buf[16*k +: 16] != fifo[k]) bad++;
        check(bad == 0, "R5 header words queue 4", bad, 0);
        check(hdr_buf[239:128] == '0, "R5 zero padding queue 4", 1, 0);
        check(n_ctrl_wr == 1, "R8 no error write on success", n_ctrl_wr, 1);
    endtask

    task automatic t_even();
        bit ok;
        int bad = 0;
        build(6, 16'h0000, 10);
        run(2'd0, ok);
        check(got_frame && n_data_rd == 13, "R9 even frame reads", n_data_rd, 13);
        for (int k = 0; k < 10; k++) if (hdr_buf[16*k +: 16] != fifo[k]) bad++;
        check(bad == 0 && hdr_buf[239:160] == '0, "R5 header words queue 1", bad, 0);
        @(negedge clk);
        check_payload("R9 even bytes base 1E", 6, 'h1E);
    endtask

    task automatic t_odd();
        bit ok;
        build(5, 16'h0004, 10);
        run(2'd2, ok);
        @(negedge clk);
        check(got_frame && n_data_rd == 13, "R10 odd frame reads", n_data_rd, 13);
        check_payload("R10 odd bytes base 20", 5, 'h20);
        build(1, 16'h0000, 10);
        run(2'd1, ok);
        @(negedge clk);
        check_payload("R10 single byte base 1E", 1, 'h1E);
    endtask

    task automatic t_invalid();
        bit ok;
        build(4, 16'h0001, 10);
        run(2'd0, ok);
        check(err_code == 3'd4 && n_data_rd == 25, "R6 invalid queue 1 dummy reads", n_data_rd, 25);
        check(n_out == 0 && wr_hist[1] == 2, "R6 invalid no payload", n_out, 0);
        run(2'd1, ok);
        check(err_code == 3'd4 && n_data_rd == 10, "R6 invalid queue 2", n_data_rd, 10);
        check(!got_frame, "R12 invalid no frame flag", got_frame, 0);
    endtask

    task automatic t_max();
        bit ok;
        build(16'h0700, 16'h0004, 10);
        run(2'd1, ok);
        @(negedge clk);
        check(got_frame && err_code == 3'd0, "R10 max length accepted", err_code, 0);
        check_payload("R10 max length bytes", 16'h0700, 'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_empty();
        t_timeout();
        t_late_ready();
        t_too_long();
        t_zero();
        t_q4_hdr();
        t_even();
        t_odd();
        t_invalid();
        t_max();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule